// File: doc/BRIEF.md
# Serial Codec Input Frame Receiver

This block sits on the controller side of a serial audio codec link and turns the codec's input bit stream into parallel words. It uses the codec bit clock as its only clock and takes every serial bit on the falling edge of that clock. A frame sync, generated elsewhere in the controller, marks where each frame starts. A frame is 256 bits long. It begins with a 16-bit tag word and continues with twelve 20-bit slots. All bits are sent MSB first.

The tag word carries two kinds of information: a readiness bit for the whole codec, and one valid flag for each slot. The block uses these flags to decide what reaches its outputs.

- Slot 1 carries an echoed register index, and slot 2 carries register read data. The block turns these into a read completion and compares the echoed index with the index of the read the controller still has outstanding.
- Slots 3 to 10 carry capture samples. Each accepted sample is presented twice: as the full 18-bit value, and as a 16-bit value that is rounded, not cut off.

The decoded outputs of a frame all change together, on the clock edge that takes the frame's last bit.

Top module: `aclink_rx_frame`

## Requirements
- R1: While reset is asserted, every output is zero: readiness, sample strobes, sample and rounded registers, read index, read data, completion and mismatch.
- R2: `link_ready_o` takes the value of tag bit 15 of each complete frame and changes at no other time. While it is 0, no link transaction may be issued.
- R3: Slot k (3 to 10) has its valid flag at tag bit 15-k. `cap_vld_o[k-3]` pulses for exactly one cycle at frame end only when both that flag and tag bit 15 are set.
- R4: The sample of a slot is the upper 18 bits (19:2) of the 20-bit slot word. Bits 1:0 have no effect. A slot's sample register holds its old value in every frame where that slot is not accepted.
- R5: The rounded output equals the 18-bit signed sample divided by 4, rounded half up (add 2, then take the floor). A result above 32767 saturates to 32767, so the rounded value never wraps.
- R6: `rd_idx_o` loads slot 1 bits 18:12 at the end of a frame whose tag bits 15 and 14 are both set. Otherwise it holds its value.
- R7: `rd_data_o` loads slot 2 bits 19:4 at the end of a frame whose tag bits 15 and 13 are both set. `rd_done_o` pulses for one cycle when tag bits 15, 14 and 13 are all set.
- R8: `rd_mismatch_o` pulses together with `rd_done_o` when `req_pend_i` is high and the echoed index differs from `req_idx_i`. It never pulses in any other case.
- R9: The first bit of a frame is sampled on the falling edge at which the sync is first seen high. A new sync rise restarts the frame at any point, and the partial frame it interrupts leaves the outputs untouched. Serial data with no sync rise is ignored.
- R10: All outputs update in one single cycle: the falling edge that samples bit 255 of a frame. Pulses are low on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Codec bit clock; every register updates on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync; a rising edge marks the first bit of a frame |
| sdata_i | input | 1 | Serial input data, MSB first |
| req_pend_i | input | 1 | A register read is outstanding |
| req_idx_i | input | 7 | Index of the outstanding register read |
| link_ready_o | output | 1 | Codec readiness from the latest complete frame |
| cap_vld_o | output | 8 | One-cycle strobe for each capture slot 3..10 |
| cap_data_o | output | 144 | Eight 18-bit samples; slot 3 in the lowest bits |
| cap_rnd_o | output | 128 | Eight 16-bit rounded samples; slot 3 in the lowest bits |
| rd_done_o | output | 1 | Read completion strobe |
| rd_idx_o | output | 7 | Latest accepted echoed register index |
| rd_data_o | output | 16 | Latest accepted register read data |
| rd_mismatch_o | output | 1 | Completion whose index differs from the pending request |

## Verification
The hardest case to reach from the ports is a sync rise that arrives in the middle of a frame. The partial frame must leave no trace, and the rebuilt frame must commit exactly 255 edges after the new rise. The stimulus reaches this case by cutting a frame off after 100 bits, with all flags set and distinctive slot contents. It then sends a full frame at once, and after that runs a long stretch of toggling data with the sync held low. A second hard area is rounding at its boundaries. The stimulus covers this with slot words near full scale and near zero, with the two dropped bits chosen both to trigger saturation and to show that they are ignored.

// File: rtl/aclk_rx_pkg.sv
package aclk_rx_pkg;

   typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;

   // Bit position, counted from the start of a frame, of the last bit of slot k
   // (k = 0 is the tag word).
   function automatic int slot_end_bit(input int tag_w, input int slot_w, input int k);
      return (k == 0) ? (tag_w - 1) : (tag_w + k * slot_w - 1);
   endfunction

endpackage

// File: rtl/aclk_rx_pos.sv
module aclk_rx_pos
   import aclk_rx_pkg::*;
#(
   parameter int FRAME_BITS = 256
) (
   input  logic                            bclk,
   input  logic                            rst_n,
   input  logic                            sync_i,
   output logic                            bit_vld_o,
   output logic [$clog2(FRAME_BITS)-1:0]   bit_pos_o,
   output logic                            frame_end_o
);
   localparam int CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   logic             sync_q;
   logic [CNT_W-1:0] pos_q;
   rx_state_e        st_q;
   logic             sync_rise;

   assign sync_rise = sync_i & ~sync_q;

   // position of the bit sampled on this edge
   always_comb begin
      bit_vld_o = 1'b0;
      bit_pos_o = '0;
      if (sync_rise) begin
         bit_vld_o = 1'b1;
      end else if (st_q == RX_RUN && pos_q != LAST) begin
         bit_vld_o = 1'b1;
         bit_pos_o = pos_q + 1'b1;
      end
   end

   assign frame_end_o = bit_vld_o && (bit_pos_o == LAST);

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         pos_q  <= '0;
         st_q   <= RX_IDLE;
      end else begin
         sync_q <= sync_i;
         if (bit_vld_o) pos_q <= bit_pos_o;
         st_q <= bit_vld_o ? RX_RUN : RX_IDLE;
      end
   end

endmodule

// File: rtl/aclk_rx_deser.sv
module aclk_rx_deser
   import aclk_rx_pkg::*;
#(
   parameter int TAG_W      = 16,
   parameter int SLOT_W     = 20,
   parameter int HOLD_SLOTS = 10,
   parameter int CNT_W      = 8
) (
   input  logic                           bclk,
   input  logic                           rst_n,
   input  logic                           sdi_i,
   input  logic                           bit_vld_i,
   input  logic [CNT_W-1:0]               bit_pos_i,
   output logic [TAG_W-1:0]               tag_o,
   output logic [HOLD_SLOTS*SLOT_W-1:0]   slots_o
);
   logic [SLOT_W-1:0] sh_q;
   logic [SLOT_W-1:0] word;
   logic [TAG_W-1:0]  tag_q;

   assign word = {sh_q[SLOT_W-2:0], sdi_i};

   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         tag_q <= '0;
      end else if (bit_vld_i) begin
         sh_q <= word;
         if (bit_pos_i == CNT_W'(slot_end_bit(TAG_W, SLOT_W, 0)))
            tag_q <= word[TAG_W-1:0];
      end
   end

   assign tag_o = tag_q;

   for (genvar k = 1; k <= HOLD_SLOTS; k++) begin : g_hold
      localparam logic [CNT_W-1:0] ENDP = CNT_W'(slot_end_bit(TAG_W, SLOT_W, k));
      logic [SLOT_W-1:0] hold_q;
      always_ff @(negedge bclk or negedge rst_n) begin
         if (!rst_n)                           hold_q <= '0;
         else if (bit_vld_i && bit_pos_i == ENDP) hold_q <= word;
      end
      assign slots_o[(k-1)*SLOT_W +: SLOT_W] = hold_q;
   end

endmodule

// File: rtl/aclk_rx_round.sv
module aclk_rx_round #(
   parameter int IN_W  = 18,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  smp_i,
   output logic [OUT_W-1:0] rnd_o
);
   logic unused_fold;
   assign unused_fold = ^smp_i;

   if (OUT_W < IN_W) begin : g_rnd
      localparam int DROP = IN_W - OUT_W;
      localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};
      logic [OUT_W-1:0] hi;
      logic             half;
      assign hi    = smp_i[IN_W-1:DROP];
      assign half  = smp_i[DROP-1];
      // half an LSB added; the only overflow case is clamped
      assign rnd_o = (half && hi == MAXP) ? MAXP : hi + OUT_W'(half);
   end else begin : g_pass
      assign rnd_o = OUT_W'(smp_i);
   end

endmodule

// File: rtl/aclink_rx_frame.sv
module aclink_rx_frame #(
   parameter int TAG_W     = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int SMP_W     = 18,
   parameter int OUT_W     = 16,
   parameter int IDX_W     = 7,
   parameter int RD_W      = 16,
   parameter int CAP_FIRST = 3,
   parameter int CAP_LAST  = 10
) (
   input  logic                                         bclk_i,
   input  logic                                         rst_ni,
   input  logic                                         sync_i,
   input  logic                                         sdata_i,
   input  logic                                         req_pend_i,
   input  logic [IDX_W-1:0]                             req_idx_i,
   output logic                                         link_ready_o,
   output logic [CAP_LAST-CAP_FIRST:0]                  cap_vld_o,
   output logic [(CAP_LAST-CAP_FIRST+1)*SMP_W-1:0]      cap_data_o,
   output logic [(CAP_LAST-CAP_FIRST+1)*OUT_W-1:0]      cap_rnd_o,
   output logic                                         rd_done_o,
   output logic [IDX_W-1:0]                             rd_idx_o,
   output logic [RD_W-1:0]                              rd_data_o,
   output logic                                         rd_mismatch_o
);
   localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);
   localparam int NCAP       = CAP_LAST - CAP_FIRST + 1;
   localparam int HOLD       = CAP_LAST;
   localparam int IDX_HI     = SLOT_W - 2;
   localparam int IDX_LO     = SLOT_W - 1 - IDX_W;
   localparam int RDY_BIT    = TAG_W - 1;
   localparam int V1_BIT     = TAG_W - 2;
   localparam int V2_BIT     = TAG_W - 3;

   // elaboration-time parameter checks
   if (SMP_W > SLOT_W)            begin : g_chk_smp  $error("SMP_W exceeds SLOT_W");        end
   if (OUT_W > SMP_W || OUT_W < 2) begin : g_chk_out  $error("OUT_W out of range");          end
   if (TAG_W > SLOT_W)            begin : g_chk_tag  $error("TAG_W exceeds SLOT_W");        end
   if (CAP_LAST > NUM_SLOTS)      begin : g_chk_last $error("CAP_LAST exceeds NUM_SLOTS");  end
   if (CAP_LAST > TAG_W - 1)      begin : g_chk_flag $error("no tag flag for CAP_LAST");    end
   if (CAP_FIRST < 3 || CAP_FIRST > CAP_LAST) begin : g_chk_first $error("bad CAP_FIRST"); end
   if (IDX_W > SLOT_W - 1 || RD_W > SLOT_W) begin : g_chk_rd $error("read field too wide"); end

   logic                      bit_vld;
   logic [CNT_W-1:0]          bit_pos;
   logic                      frame_end;
   logic [TAG_W-1:0]          tag;
   logic [HOLD*SLOT_W-1:0]    slots;
   logic                      rdy_now;
   logic [IDX_W-1:0]          echo_idx;
   logic [RD_W-1:0]           echo_data;
   logic                      unused_fold;

   aclk_rx_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
      .bclk        (bclk_i),
      .rst_n       (rst_ni),
      .sync_i      (sync_i),
      .bit_vld_o   (bit_vld),
      .bit_pos_o   (bit_pos),
      .frame_end_o (frame_end)
   );

   aclk_rx_deser #(
      .TAG_W(TAG_W), .SLOT_W(SLOT_W), .HOLD_SLOTS(HOLD), .CNT_W(CNT_W)
   ) u_deser (
      .bclk      (bclk_i),
      .rst_n     (rst_ni),
      .sdi_i     (sdata_i),
      .bit_vld_i (bit_vld),
      .bit_pos_i (bit_pos),
      .tag_o     (tag),
      .slots_o   (slots)
   );

   assign unused_fold = ^{tag, slots};
   assign rdy_now     = tag[RDY_BIT];
   assign echo_idx    = slots[IDX_HI:IDX_LO];
   assign echo_data   = slots[SLOT_W + SLOT_W - 1 -: RD_W];

   // codec readiness and read-back path
   logic             ready_q;
   logic             done_q;
   logic             mis_q;
   logic [IDX_W-1:0] idx_q;
   logic [RD_W-1:0]  rdat_q;

   always_ff @(negedge bclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ready_q <= 1'b0;
         done_q  <= 1'b0;
         mis_q   <= 1'b0;
         idx_q   <= '0;
         rdat_q  <= '0;
      end else begin
         done_q <= 1'b0;
         mis_q  <= 1'b0;
         if (frame_end) begin
            ready_q <= rdy_now;
            if (rdy_now) begin
               if (tag[V1_BIT]) idx_q  <= echo_idx;
               if (tag[V2_BIT]) rdat_q <= echo_data;
               if (tag[V1_BIT] && tag[V2_BIT]) begin
                  done_q <= 1'b1;
                  mis_q  <= req_pend_i && (echo_idx != req_idx_i);
               end
            end
         end
      end
   end

   assign link_ready_o  = ready_q;
   assign rd_done_o     = done_q;
   assign rd_mismatch_o = mis_q;
   assign rd_idx_o      = idx_q;
   assign rd_data_o     = rdat_q;

   // capture slots
   for (genvar c = 0; c < NCAP; c++) begin : g_cap
      localparam int K     = CAP_FIRST + c;
      localparam int WBASE = (K - 1) * SLOT_W;
      logic [SMP_W-1:0] smp;
      logic [OUT_W-1:0] rnd;
      logic             take;
      logic             vld_q;
      logic [SMP_W-1:0] dat_q;
      logic [OUT_W-1:0] rnd_q;

      assign smp  = slots[WBASE + SLOT_W - 1 -: SMP_W];
      assign take = frame_end && rdy_now && tag[TAG_W-1-K];

      aclk_rx_round #(.IN_W(SMP_W), .OUT_W(OUT_W)) u_rnd (
         .smp_i (smp),
         .rnd_o (rnd)
      );

      always_ff @(negedge bclk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q <= 1'b0;
            dat_q <= '0;
            rnd_q <= '0;
         end else begin
            vld_q <= take;
            if (take) begin
               dat_q <= smp;
               rnd_q <= rnd;
            end
         end
      end

      assign cap_vld_o[c]                 = vld_q;
      assign cap_data_o[c*SMP_W +: SMP_W] = dat_q;
      assign cap_rnd_o[c*OUT_W +: OUT_W]  = rnd_q;
   end

endmodule

// File: rtl/aclink_rx_frame_chk.sv
module aclink_rx_frame_chk #(
   parameter int NCAP  = 8,
   parameter int SMP_W = 18,
   parameter int OUT_W = 16
) (
   input logic                    bclk,
   input logic                    rst_n,
   input logic                    frame_end,
   input logic                    link_ready,
   input logic [NCAP-1:0]         cap_vld,
   input logic [NCAP*SMP_W-1:0]   cap_data,
   input logic [NCAP*OUT_W-1:0]   cap_rnd,
   input logic                    rd_done,
   input logic                    rd_mismatch
);

   p_ready_only_at_end_r2: assert property (@(negedge bclk) disable iff (!rst_n)
      !frame_end |=> $stable(link_ready));

   p_strobe_needs_ready_r3: assert property (@(negedge bclk) disable iff (!rst_n)
      (|cap_vld) |-> link_ready);

   p_strobe_single_r3: assert property (@(negedge bclk) disable iff (!rst_n)
      (|cap_vld) |=> (cap_vld == '0));

   p_done_needs_ready_r7: assert property (@(negedge bclk) disable iff (!rst_n)
      rd_done |-> link_ready);

   p_mismatch_with_done_r8: assert property (@(negedge bclk) disable iff (!rst_n)
      rd_mismatch |-> rd_done);

   p_quiet_off_end_r10: assert property (@(negedge bclk) disable iff (!rst_n)
      !frame_end |=> (cap_vld == '0 && !rd_done));

   for (genvar c = 0; c < NCAP; c++) begin : g_slot
      p_hold_data_r4: assert property (@(negedge bclk) disable iff (!rst_n)
         !cap_vld[c] |-> ($stable(cap_data[c*SMP_W +: SMP_W]) &&
                          $stable(cap_rnd[c*OUT_W +: OUT_W])));

      p_no_wrap_r5: assert property (@(negedge bclk) disable iff (!rst_n)
         (cap_vld[c] && !cap_data[c*SMP_W + SMP_W - 1]) |-> !cap_rnd[c*OUT_W + OUT_W - 1]);
   end

endmodule

bind aclink_rx_frame aclink_rx_frame_chk #(
   .NCAP(NCAP), .SMP_W(SMP_W), .OUT_W(OUT_W)
) u_chk (
   .bclk        (bclk_i),
   .rst_n       (rst_ni),
   .frame_end   (frame_end),
   .link_ready  (link_ready_o),
   .cap_vld     (cap_vld_o),
   .cap_data    (cap_data_o),
   .cap_rnd     (cap_rnd_o),
   .rd_done     (rd_done_o),
   .rd_mismatch (rd_mismatch_o)
);

// File: tb/aclink_rx_frame_tb_top.sv
module aclink_rx_frame_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 8;

   logic          bclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0;
   logic          sdata = 1'b0;
   logic          req_pend = 1'b0;
   logic [6:0]    req_idx = '0;
   logic          link_ready;
   logic [NC-1:0] cap_vld;
   logic [NC*18-1:0] cap_data;
   logic [NC*16-1:0] cap_rnd;
   logic          rd_done;
   logic [6:0]    rd_idx;
   logic [15:0]   rd_data;
   logic          rd_mismatch;

   aclink_rx_frame dut_i (
      .bclk_i(bclk), .rst_ni(rst_n), .sync_i(sync), .sdata_i(sdata),
      .req_pend_i(req_pend), .req_idx_i(req_idx),
      .link_ready_o(link_ready), .cap_vld_o(cap_vld), .cap_data_o(cap_data),
      .cap_rnd_o(cap_rnd), .rd_done_o(rd_done), .rd_idx_o(rd_idx),
      .rd_data_o(rd_data), .rd_mismatch_o(rd_mismatch)
   );

   always #(CLK_PERIOD/2) bclk = ~bclk;

   // reference state
   logic          e_ready = 1'b0;
   logic [NC-1:0] e_vld = '0;
   logic [17:0]   e_data [NC];
   logic [15:0]   e_rnd [NC];
   logic          e_done = 1'b0;
   logic          e_mis = 1'b0;
   logic [6:0]    e_idx = '0;
   logic [15:0]   e_rdat = '0;
   string         phase = "R1 reset";
   int            vectors = 0;
   int            miscompares = 0;

   initial begin
      for (int c = 0; c < NC; c++) begin e_data[c] = '0; e_rnd[c] = '0; end
   end

   function automatic logic [15:0] ref_round(input logic [17:0] s);
      int v, r;
      v = int'(s);
      if (v >= 131072) v = v - 262144;
      v = v + 2;
      r = (v >= 0) ? v / 4 : -((-v + 3) / 4);
      if (r > 32767) r = 32767;
      return 16'(r);
   endfunction

   task automatic report(input string req, input logic [143:0] act, input logic [143:0] exp);
      miscompares++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
   endtask

   // compare every clock, away from the sampling (falling) edge
   always @(posedge bclk) begin
      string rq;
      vectors++;
      rq = rst_n ? "R2" : "R1";
      if (link_ready !== e_ready) report(rq, 144'(link_ready), 144'(e_ready));
      if (!rst_n) rq = "R1"; else rq = "R3/R10";
      if (cap_vld !== e_vld) report(rq, 144'(cap_vld), 144'(e_vld));
      for (int c = 0; c < NC; c++) begin
         if (cap_data[c*18 +: 18] !== e_data[c])
            report(rst_n ? "R4" : "R1", 144'(cap_data[c*18 +: 18]), 144'(e_data[c]));
         if (cap_rnd[c*16 +: 16] !== e_rnd[c])
            report(rst_n ? "R5" : "R1", 144'(cap_rnd[c*16 +: 16]), 144'(e_rnd[c]));
      end
      if (rd_idx !== e_idx) report(rst_n ? "R6" : "R1", 144'(rd_idx), 144'(e_idx));
      if (rd_data !== e_rdat) report(rst_n ? "R7" : "R1", 144'(rd_data), 144'(e_rdat));
      if (rd_done !== e_done) report(rst_n ? "R7" : "R1", 144'(rd_done), 144'(e_done));
      if (rd_mismatch !== e_mis) report(rst_n ? "R8" : "R1", 144'(rd_mismatch), 144'(e_mis));
   end

   // nbits < 256 sends a cut-off frame that must leave no trace (R9)
   task automatic send_frame(input logic [15:0] tag, input logic [19:0] sl [12], input int nbits);
      logic [255:0] fr;
      fr[255 -: 16] = tag;
      for (int k = 0; k < 12; k++) fr[239 - 20*k -: 20] = sl[k];
      for (int b = 0; b < nbits; b++) begin
         @(posedge bclk); #1;
         sync  = (b < 16);
         sdata = fr[255 - b];
      end
      if (nbits == 256) begin
         @(negedge bclk); #1;
         e_ready = tag[15];
         if (tag[15]) begin
            for (int c = 0; c < NC; c++)
               if (tag[15 - (c + 3)]) begin
                  e_vld[c]  = 1'b1;
                  e_data[c] = sl[c + 2][19:2];
                  e_rnd[c]  = ref_round(sl[c + 2][19:2]);
               end
            if (tag[14]) e_idx = sl[0][18:12];
            if (tag[13]) e_rdat = sl[1][19:4];
            if (tag[14] && tag[13]) begin
               e_done = 1'b1;
               e_mis  = req_pend && (sl[0][18:12] != req_idx);
            end
         end
         @(negedge bclk); #1;
         e_vld = '0; e_done = 1'b0; e_mis = 1'b0;
      end
   endtask

   task automatic fill_random(output logic [19:0] sl [12]);
      for (int k = 0; k < 12; k++) sl[k] = 20'($urandom);
   endtask

   initial begin
      logic [19:0] sl [12];
      repeat (4) @(posedge bclk);
      #1 rst_n = 1'b1;
      phase = "R2 idle";
      repeat (5) @(posedge bclk);

      // not ready: flags set but nothing may be accepted (R2, R3)
      phase = "R2 not ready";
      fill_random(sl);
      send_frame(16'h7FE0, sl, 256);

      // ready, all flags, rounding corners (R4, R5); low two bits set to show they are ignored
      phase = "R5 rounding corners";
      fill_random(sl);
      sl[2] = {18'h1FFFE, 2'b11};   // saturates
      sl[3] = {18'h1FFFD, 2'b00};   // max without rounding up
      sl[4] = {18'h3FFFE, 2'b10};   // -2 -> 0
      sl[5] = {18'h3FFFD, 2'b01};   // -3 -> -1
      sl[6] = {18'h00002, 2'b11};   // rounds up to 1
      sl[7] = {18'h00001, 2'b00};   // rounds to 0
      sl[8] = {18'h20000, 2'b11};   // most negative
      sl[9] = {18'h0ABCD, 2'b10};
      req_pend = 1'b1; req_idx = sl[0][18:12];
      send_frame(16'hFFE0, sl, 256);

      // same samples, only dropped bits changed, odd slots valid (R4)
      phase = "R4 low bits";
      for (int k = 2; k < 10; k++) sl[k][1:0] = ~sl[k][1:0];
      send_frame(16'h9540, sl, 256);

      // read mismatch (R8)
      phase = "R8 mismatch";
      fill_random(sl);
      req_pend = 1'b1; req_idx = sl[0][18:12] ^ 7'h11;
      send_frame(16'hE000, sl, 256);

      // no pending request: differing index gives no mismatch (R8)
      phase = "R8 no pending";
      fill_random(sl);
      req_pend = 1'b0;
      send_frame(16'hE000, sl, 256);

      // index without data, then data without index (R6, R7)
      phase = "R6 index only";
      fill_random(sl);
      send_frame(16'hC000, sl, 256);
      phase = "R7 data only";
      fill_random(sl);
      send_frame(16'hA000, sl, 256);

      // cut-off frame, then an immediate full frame (R9)
      phase = "R9 abort";
      fill_random(sl);
      send_frame(16'hFFE0, sl, 100);
      fill_random(sl);
      req_pend = 1'b1; req_idx = sl[0][18:12];
      send_frame(16'hF0A0, sl, 256);

      // serial data with no sync rise is ignored (R9)
      phase = "R9 no sync";
      for (int b = 0; b < 300; b++) begin
         @(posedge bclk); #1;
         sync = 1'b0; sdata = 1'($urandom);
      end

      // readiness drops again (R2, R3)
      phase = "R2 ready drop";
      fill_random(sl);
      send_frame(16'h7FE0, sl, 256);

      // mixed random frames (R10)
      phase = "R10 random";
      for (int f = 0; f < 12; f++) begin
         logic [15:0] t;
         fill_random(sl);
         t = 16'($urandom) & 16'hFFE0;
         req_pend = 1'($urandom);
         req_idx = (f % 2 == 0) ? sl[0][18:12] : 7'($urandom);
         send_frame(t, sl, 256);
      end

      repeat (5) @(posedge bclk);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge bclk);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule